// File: doc/BRIEF.md
# Not-There Register Tracker with Defer Decision

This block keeps per-register availability state for a speculatively running ahead thread. Each cycle it takes a small group of issued instructions, each with its source and destination register indices, a flag marking a load that missed the first-level cache, and the operand values the register file currently holds. For each slot it decides whether the instruction can run now or must be parked in the deferred queue. A parked instruction leaves with its opcode, its register indices and a copy of every operand that was already available, so that later ahead-thread writes cannot disturb it.

Availability is a single bit per register, the not-there bit. It is set when a register waits on a deferred result and cleared when an instruction produces a real value. Dependency propagation is a plain OR over the sources' bits, so no renaming or associative wakeup is involved. Three more vectors follow the behind thread, which replays the deferred queue: a snapshot of the not-there vector taken when the behind thread starts, a written vector, and a write-after-write vector. These vectors decide whether a behind-thread result may update architectural state or may only be forwarded. The block also applies the vector updates for merge and for the final join of an episode.

Top module: `ntdefer_top`

## Requirements
- R1: A valid slot flagged as a cache-missing load is deferred, and after the clock edge its destination's not-there bit is 1.
- R2: A valid slot is deferred when any used source (its `iss_src_use` bit is 1) has its not-there bit set, and its destination bit becomes 1. A source whose use bit is 0 has no effect on the decision.
- R3: A valid slot that is not a missing load and has all used sources available is executed (`iss_exec`=1, `iss_defer`=0), and its destination bit becomes 0 even if it was 1. No slot is executed and deferred at once.
- R4: For a deferred slot, `dq_we` is 1 and the entry carries the slot's opcode, destination and source indices. `dq_rdy` bit s is 1 when source s was available. `dq_opnd` for source s holds the input operand value when that bit is 1 and zero otherwise.
- R5: Slots are handled in program order, slot 0 being oldest. A slot sees the not-there bits left by all older slots of the same group, and when two slots write one register, the youngest decides that register's final bit.
- R6: While `dq_full` is 1 and any slot of the group needs deferral, `stall` is 1. The whole group is then refused: no `iss_exec`, no `iss_defer`, no `dq_we`, and the not-there vector is unchanged by issue.
- R7: `bt_start` clears the written vector and copies the not-there vector into the snapshot vector.
- R8: A behind-thread write sets the target's written bit. If the target's not-there and snapshot bits differ, its write-after-write bit is set and `bt_arch_ok` is 0. Otherwise `bt_arch_ok` is 1.
- R9: `bt_merge` sets the not-there vector to snapshot AND written, and clears both the snapshot and written vectors. The write-after-write vector is kept.
- R10: `bt_join` applies the merge update and, in the same cycle, presents the write-after-write vector on `drop_mask` as the registers whose behind-thread values are discarded. After the edge the write-after-write vector is zero.
- R11: In one cycle the updates apply in this order: the behind-thread write first, then the control command (join over merge over start), and then issue. Issue decisions read the not-there vector after the control command.
- R12: After reset all four vectors are zero and no slot is executed or deferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | ISSUE | Slot holds an instruction |
| iss_miss | input | ISSUE | Slot is a load that missed the cache |
| iss_op | input | ISSUE*OPW | Opcode per slot |
| iss_src | input | ISSUE*NSRC*AW | Source register indices |
| iss_src_use | input | ISSUE*NSRC | Source is actually read |
| iss_dst | input | ISSUE*AW | Destination register index |
| iss_dst_use | input | ISSUE | Slot writes a destination |
| iss_opnd | input | ISSUE*NSRC*DW | Current operand values |
| dq_full | input | 1 | Deferred queue cannot take entries |
| bt_start | input | 1 | Behind thread starts |
| bt_merge | input | 1 | Merge the current checkpoint |
| bt_join | input | 1 | Final merge, episode ends |
| bt_wr_valid | input | 1 | Behind thread writes a register |
| bt_wr_dst | input | AW | Behind-thread write target |
| iss_exec | output | ISSUE | Slot executes now |
| iss_defer | output | ISSUE | Slot goes to the deferred queue |
| stall | output | 1 | Group refused because the queue is full |
| dq_we | output | ISSUE | Deferred-queue write per slot |
| dq_op | output | ISSUE*OPW | Entry opcode |
| dq_dst | output | ISSUE*AW | Entry destination |
| dq_src | output | ISSUE*NSRC*AW | Entry source indices |
| dq_rdy | output | ISSUE*NSRC | Entry source was available |
| dq_opnd | output | ISSUE*NSRC*DW | Captured operand values |
| bt_arch_ok | output | 1 | Behind-thread write may update architectural state |
| drop_mask | output | NREG | Registers whose behind values are dropped at join |
| nt_vec | output | NREG | Not-there vector |
| snt_vec | output | NREG | Snapshot vector |
| w_vec | output | NREG | Written vector |
| waw_vec | output | NREG | Write-after-write vector |

## Verification
The defer decision is driven with two-slot groups that cover a missing load feeding a younger consumer in the same group, an executed producer clearing a pending register, and two writers to one register where the older one defers and the younger one executes. These groups separate a chain that respects program order from one that reads only the registered vector. Other groups have one slot idle, which shows that an empty slot neither defers nor disturbs the vector. A full queue is shown once with a group that needs deferral and once with a group that only executes, which separates a true stall from a blanket refusal. One cycle carries a behind-thread write, a merge and a missing load together, and the resulting vector shows whether the updates apply in the required order.

// File: rtl/ntdefer_pkg.sv
package ntdefer_pkg;

    // Episode control command after priority resolution (join > merge > start)
    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_START = 2'd1,
        CTL_MERGE = 2'd2,
        CTL_JOIN  = 2'd3
    } ctl_e;

    function automatic ctl_e pick_ctl(input logic start, input logic merge, input logic join_i);
        if (join_i)      return CTL_JOIN;
        else if (merge)  return CTL_MERGE;
        else if (start)  return CTL_START;
        else             return CTL_IDLE;
    endfunction

endpackage

// File: rtl/ntdefer_slot.sv
// One issue slot: reads the incoming not-there vector, decides defer/execute
// and hands the updated vector to the next (younger) slot.
module ntdefer_slot #(
    parameter int NREG = 32,
    parameter int NSRC = 2,
    parameter int AW   = 5
) (
    input  logic                     valid,
    input  logic                     miss,
    input  logic [NSRC-1:0][AW-1:0]  src,
    input  logic [NSRC-1:0]          src_use,
    input  logic [AW-1:0]            dst,
    input  logic                     dst_use,
    input  logic [NREG-1:0]          nt_in,
    output logic                     defer,
    output logic [NSRC-1:0]          src_rdy,
    output logic [NREG-1:0]          nt_out
);

    logic pending;

    always_comb begin
        src_rdy = '1;
        pending = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            if (src_use[s] && nt_in[src[s]]) begin
                src_rdy[s] = 1'b0;
                pending    = 1'b1;
            end
        end
        defer  = valid & (miss | pending);
        nt_out = nt_in;
        if (valid && dst_use) begin
            nt_out[dst] = defer;
        end
    end

endmodule

// File: rtl/ntdefer_bt.sv
// Behind-thread write bookkeeping and episode control vector updates.
module ntdefer_bt
    import ntdefer_pkg::*;
#(
    parameter int NREG = 32,
    parameter int AW   = 5
) (
    input  logic [NREG-1:0] nt_q,
    input  logic [NREG-1:0] snt_q,
    input  logic [NREG-1:0] w_q,
    input  logic [NREG-1:0] waw_q,
    input  logic            wr_valid,
    input  logic [AW-1:0]   wr_dst,
    input  ctl_e            ctl,
    output logic [NREG-1:0] nt_o,
    output logic [NREG-1:0] snt_o,
    output logic [NREG-1:0] w_o,
    output logic [NREG-1:0] waw_o,
    output logic            arch_ok,
    output logic [NREG-1:0] drop
);

    logic [NREG-1:0] w_wr;
    logic [NREG-1:0] waw_wr;

    // Step 1: behind-thread write
    always_comb begin
        w_wr    = w_q;
        waw_wr  = waw_q;
        arch_ok = 1'b0;
        if (wr_valid) begin
            w_wr[wr_dst] = 1'b1;
            if (nt_q[wr_dst] != snt_q[wr_dst]) begin
                waw_wr[wr_dst] = 1'b1;
            end else begin
                arch_ok = 1'b1;
            end
        end
    end

    // Step 2: control command on top of the write
    always_comb begin
        nt_o  = nt_q;
        snt_o = snt_q;
        w_o   = w_wr;
        waw_o = waw_wr;
        drop  = '0;
        unique case (ctl)
            CTL_JOIN: begin
                nt_o  = snt_q & w_wr;
                snt_o = '0;
                w_o   = '0;
                drop  = waw_wr;
                waw_o = '0;
            end
            CTL_MERGE: begin
                nt_o  = snt_q & w_wr;
                snt_o = '0;
                w_o   = '0;
            end
            CTL_START: begin
                snt_o = nt_q;
                w_o   = '0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ntdefer_dq_pack.sv
// Builds the operand fields of deferred-queue entries: available values are
// captured, unavailable ones are zeroed.
module ntdefer_dq_pack #(
    parameter int ISSUE = 2,
    parameter int NSRC  = 2,
    parameter int DW    = 32
) (
    input  logic [ISSUE-1:0][NSRC-1:0]         rdy,
    input  logic [ISSUE-1:0][NSRC-1:0][DW-1:0] opnd_in,
    output logic [ISSUE-1:0][NSRC-1:0][DW-1:0] opnd_out
);

    for (genvar i = 0; i < ISSUE; i++) begin : g_slot
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            assign opnd_out[i][s] = rdy[i][s] ? opnd_in[i][s] : '0;
        end
    end

endmodule

// File: rtl/ntdefer_top.sv
module ntdefer_top
    import ntdefer_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int DW    = 32,
    parameter int NSRC  = 2,
    parameter int ISSUE = 2,
    parameter int OPW   = 8,
    localparam int AW   = $clog2(NREG)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ISSUE-1:0]                    iss_valid,
    input  logic [ISSUE-1:0]                    iss_miss,
    input  logic [ISSUE-1:0][OPW-1:0]           iss_op,
    input  logic [ISSUE-1:0][NSRC-1:0][AW-1:0]  iss_src,
    input  logic [ISSUE-1:0][NSRC-1:0]          iss_src_use,
    input  logic [ISSUE-1:0][AW-1:0]            iss_dst,
    input  logic [ISSUE-1:0]                    iss_dst_use,
    input  logic [ISSUE-1:0][NSRC-1:0][DW-1:0]  iss_opnd,
    input  logic                                dq_full,
    input  logic                                bt_start,
    input  logic                                bt_merge,
    input  logic                                bt_join,
    input  logic                                bt_wr_valid,
    input  logic [AW-1:0]                       bt_wr_dst,
    output logic [ISSUE-1:0]                    iss_exec,
    output logic [ISSUE-1:0]                    iss_defer,
    output logic                                stall,
    output logic [ISSUE-1:0]                    dq_we,
    output logic [ISSUE-1:0][OPW-1:0]           dq_op,
    output logic [ISSUE-1:0][AW-1:0]            dq_dst,
    output logic [ISSUE-1:0][NSRC-1:0][AW-1:0]  dq_src,
    output logic [ISSUE-1:0][NSRC-1:0]          dq_rdy,
    output logic [ISSUE-1:0][NSRC-1:0][DW-1:0]  dq_opnd,
    output logic                                bt_arch_ok,
    output logic [NREG-1:0]                     drop_mask,
    output logic [NREG-1:0]                     nt_vec,
    output logic [NREG-1:0]                     snt_vec,
    output logic [NREG-1:0]                     w_vec,
    output logic [NREG-1:0]                     waw_vec
);

    typedef struct packed {
        logic [NREG-1:0] nt;
        logic [NREG-1:0] snt;
        logic [NREG-1:0] w;
        logic [NREG-1:0] waw;
    } vec_state_t;

    vec_state_t st_q, st_d;

    ctl_e            ctl;
    logic [NREG-1:0] nt_ctl, snt_ctl, w_ctl, waw_ctl;

    logic [NREG-1:0] nt_chain [ISSUE+1];
    logic            defer_raw [ISSUE];
    logic [NSRC-1:0] rdy_w [ISSUE];
    logic [ISSUE-1:0][NSRC-1:0] rdy_pk;
    logic            any_def;

    assign ctl = pick_ctl(bt_start, bt_merge, bt_join);

    ntdefer_bt #(.NREG(NREG), .AW(AW)) u_bt (
        .nt_q     (st_q.nt),
        .snt_q    (st_q.snt),
        .w_q      (st_q.w),
        .waw_q    (st_q.waw),
        .wr_valid (bt_wr_valid),
        .wr_dst   (bt_wr_dst),
        .ctl      (ctl),
        .nt_o     (nt_ctl),
        .snt_o    (snt_ctl),
        .w_o      (w_ctl),
        .waw_o    (waw_ctl),
        .arch_ok  (bt_arch_ok),
        .drop     (drop_mask)
    );

    // Issue reads the vector after the control command
    assign nt_chain[0] = nt_ctl;

    for (genvar i = 0; i < ISSUE; i++) begin : g_slot
        ntdefer_slot #(.NREG(NREG), .NSRC(NSRC), .AW(AW)) u_slot (
            .valid   (iss_valid[i]),
            .miss    (iss_miss[i]),
            .src     (iss_src[i]),
            .src_use (iss_src_use[i]),
            .dst     (iss_dst[i]),
            .dst_use (iss_dst_use[i]),
            .nt_in   (nt_chain[i]),
            .defer   (defer_raw[i]),
            .src_rdy (rdy_w[i]),
            .nt_out  (nt_chain[i+1])
        );
    end

    ntdefer_dq_pack #(.ISSUE(ISSUE), .NSRC(NSRC), .DW(DW)) u_pack (
        .rdy      (rdy_pk),
        .opnd_in  (iss_opnd),
        .opnd_out (dq_opnd)
    );

    always_comb begin
        any_def = 1'b0;
        for (int i = 0; i < ISSUE; i++) begin
            any_def = any_def | defer_raw[i];
        end
        stall = dq_full & any_def;

        for (int i = 0; i < ISSUE; i++) begin
            iss_defer[i] = defer_raw[i] & ~stall;
            iss_exec[i]  = iss_valid[i] & ~defer_raw[i] & ~stall;
            dq_we[i]     = defer_raw[i] & ~stall;
            rdy_pk[i]    = rdy_w[i];
        end

        dq_op  = iss_op;
        dq_dst = iss_dst;
        dq_src = iss_src;
        dq_rdy = rdy_pk;

        st_d.nt  = stall ? nt_chain[0] : nt_chain[ISSUE];
        st_d.snt = snt_ctl;
        st_d.w   = w_ctl;
        st_d.waw = waw_ctl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nt_vec  = st_q.nt;
    assign snt_vec = st_q.snt;
    assign w_vec   = st_q.w;
    assign waw_vec = st_q.waw;

endmodule

// File: rtl/ntdefer_chk.sv
module ntdefer_chk #(
    parameter int NREG  = 32,
    parameter int DW    = 32,
    parameter int NSRC  = 2,
    parameter int ISSUE = 2,
    parameter int AW    = 5
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [ISSUE-1:0]                    iss_valid,
    input logic [ISSUE-1:0]                    iss_miss,
    input logic [ISSUE-1:0][AW-1:0]            iss_dst,
    input logic [ISSUE-1:0]                    iss_dst_use,
    input logic                                bt_start,
    input logic                                bt_merge,
    input logic                                bt_join,
    input logic                                bt_wr_valid,
    input logic [AW-1:0]                       bt_wr_dst,
    input logic [ISSUE-1:0]                    iss_exec,
    input logic [ISSUE-1:0]                    iss_defer,
    input logic                                stall,
    input logic [ISSUE-1:0]                    dq_we,
    input logic [ISSUE-1:0][NSRC-1:0]          dq_rdy,
    input logic [ISSUE-1:0][NSRC-1:0][DW-1:0]  dq_opnd,
    input logic                                bt_arch_ok,
    input logic [NREG-1:0]                     nt_vec,
    input logic [NREG-1:0]                     snt_vec,
    input logic [NREG-1:0]                     w_vec,
    input logic [NREG-1:0]                     waw_vec
);

    // R1
    a_r1_miss_defers: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[0] && iss_miss[0] && !stall |-> iss_defer[0]);

    // R3
    a_r3_exec_defer_excl: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[0] |-> !(iss_exec[0] && iss_defer[0]));

    // R4
    a_r4_unready_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        dq_we[0] && !dq_rdy[0][0] |-> dq_opnd[0][0] == '0);

    // R5
    a_r5_youngest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[ISSUE-1] && iss_dst_use[ISSUE-1] && !stall
        |=> nt_vec[$past(iss_dst[ISSUE-1])] == $past(iss_defer[ISSUE-1]));

    // R6
    a_r6_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (iss_exec == '0 && iss_defer == '0 && dq_we == '0));

    a_r6_stall_holds_nt: assert property (@(posedge clk) disable iff (!rst_n)
        stall && !bt_merge && !bt_join |=> nt_vec == $past(nt_vec));

    // R7
    a_r7_start_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        bt_start && !bt_merge && !bt_join |=> (w_vec == '0 && snt_vec == $past(nt_vec)));

    // R8
    a_r8_waw_blocks_arch: assert property (@(posedge clk) disable iff (!rst_n)
        bt_wr_valid && (nt_vec[bt_wr_dst] != snt_vec[bt_wr_dst]) |-> !bt_arch_ok);

    a_r8_waw_sets: assert property (@(posedge clk) disable iff (!rst_n)
        bt_wr_valid && (nt_vec[bt_wr_dst] != snt_vec[bt_wr_dst]) && !bt_join
        |=> waw_vec[$past(bt_wr_dst)]);

    // R9
    a_r9_merge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bt_merge || bt_join |=> (snt_vec == '0 && w_vec == '0));

    // R10
    a_r10_join_clears_waw: assert property (@(posedge clk) disable iff (!rst_n)
        bt_join |=> waw_vec == '0);

endmodule

bind ntdefer_top ntdefer_chk #(
    .NREG(NREG), .DW(DW), .NSRC(NSRC), .ISSUE(ISSUE), .AW(AW)
) u_chk (.*);

// File: tb/ntdefer_top_tb.sv
module ntdefer_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 32;
    localparam int DW   = 32;
    localparam int NSRC = 2;
    localparam int ISS  = 2;
    localparam int OPW  = 8;
    localparam int AW   = 5;
    localparam int NVEC = 8;

    typedef struct packed {
        logic v0; logic m0; logic [4:0] a0; logic [4:0] b0; logic [4:0] d0;
        logic v1; logic m1; logic [4:0] a1; logic [4:0] b1; logic [4:0] d1;
        logic ed0; logic ed1;
        logic [31:0] ent;
    } vec_t;

    // expected defer per slot and the not-there vector after the edge
    localparam vec_t TBL [NVEC] = '{
        '{1'b1,1'b1,5'd0,5'd0,5'd1, 1'b1,1'b0,5'd1,5'd2,5'd3, 1'b1,1'b1, 32'h0000_000A},
        '{1'b1,1'b0,5'd2,5'd4,5'd3, 1'b1,1'b0,5'd3,5'd1,5'd5, 1'b0,1'b1, 32'h0000_0022},
        '{1'b1,1'b0,5'd5,5'd2,5'd6, 1'b1,1'b0,5'd2,5'd4,5'd6, 1'b1,1'b0, 32'h0000_0022},
        '{1'b1,1'b0,5'd2,5'd2,5'd5, 1'b1,1'b0,5'd7,5'd8,5'd1, 1'b0,1'b0, 32'h0000_0000},
        '{1'b1,1'b1,5'd0,5'd0,5'd9, 1'b0,1'b0,5'd0,5'd0,5'd0, 1'b1,1'b0, 32'h0000_0200},
        '{1'b0,1'b0,5'd0,5'd0,5'd0, 1'b1,1'b0,5'd9,5'd2,5'd9, 1'b0,1'b1, 32'h0000_0200},
        '{1'b1,1'b0,5'd2,5'd9,5'd4, 1'b1,1'b1,5'd4,5'd0,5'd2, 1'b1,1'b1, 32'h0000_0214},
        '{1'b1,1'b0,5'd2,5'd3,5'd7, 1'b1,1'b0,5'd3,5'd3,5'd2, 1'b1,1'b0, 32'h0000_0290}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ISS-1:0] iss_valid, iss_miss, iss_dst_use;
    logic [ISS-1:0][OPW-1:0] iss_op;
    logic [ISS-1:0][NSRC-1:0][AW-1:0] iss_src;
    logic [ISS-1:0][NSRC-1:0] iss_src_use;
    logic [ISS-1:0][AW-1:0] iss_dst;
    logic [ISS-1:0][NSRC-1:0][DW-1:0] iss_opnd;
    logic dq_full, bt_start, bt_merge, bt_join, bt_wr_valid;
    logic [AW-1:0] bt_wr_dst;
    logic [ISS-1:0] iss_exec, iss_defer, dq_we;
    logic stall, bt_arch_ok;
    logic [ISS-1:0][OPW-1:0] dq_op;
    logic [ISS-1:0][AW-1:0] dq_dst;
    logic [ISS-1:0][NSRC-1:0][AW-1:0] dq_src;
    logic [ISS-1:0][NSRC-1:0] dq_rdy;
    logic [ISS-1:0][NSRC-1:0][DW-1:0] dq_opnd;
    logic [NREG-1:0] drop_mask, nt_vec, snt_vec, w_vec, waw_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ntdefer_top #(.NREG(NREG), .DW(DW), .NSRC(NSRC), .ISSUE(ISS), .OPW(OPW)) u_dut (
        .clk, .rst_n, .iss_valid, .iss_miss, .iss_op, .iss_src, .iss_src_use,
        .iss_dst, .iss_dst_use, .iss_opnd, .dq_full, .bt_start, .bt_merge,
        .bt_join, .bt_wr_valid, .bt_wr_dst, .iss_exec, .iss_defer, .stall,
        .dq_we, .dq_op, .dq_dst, .dq_src, .dq_rdy, .dq_opnd, .bt_arch_ok,
        .drop_mask, .nt_vec, .snt_vec, .w_vec, .waw_vec
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        iss_valid = '0; iss_miss = '0; iss_op = '0; iss_src = '0;
        iss_src_use = '0; iss_dst = '0; iss_dst_use = '0; iss_opnd = '0;
        dq_full = 1'b0; bt_start = 1'b0; bt_merge = 1'b0; bt_join = 1'b0;
        bt_wr_valid = 1'b0; bt_wr_dst = '0;
    endtask

    task automatic set_slot(input int i, input logic v, input logic m,
                            input logic [4:0] a, input logic [4:0] b,
                            input logic [4:0] d, input logic [1:0] use_m);
        iss_valid[i] = v; iss_miss[i] = m;
        iss_src[i][0] = a; iss_src[i][1] = b;
        iss_src_use[i] = use_m; iss_dst[i] = d; iss_dst_use[i] = v;
        iss_op[i] = 8'h40 + 8'(i);
        iss_opnd[i][0] = 32'h100 + 32'(a);
        iss_opnd[i][1] = 32'h100 + 32'(b);
    endtask

    // advance through one rising edge, inputs applied after a falling edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [31:0] prev_nt;
        logic [1:0] exp_rdy;
        clear_in();
        repeat (2) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12 nt", 64'(nt_vec), 64'h0);
        chk("R12 snt", 64'(snt_vec), 64'h0);
        chk("R12 w", 64'(w_vec), 64'h0);
        chk("R12 waw", 64'(waw_vec), 64'h0);
        chk("R12 exec/defer", 64'({iss_exec, iss_defer}), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R4 R5
        prev_nt = '0;
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            clear_in();
            set_slot(0, TBL[k].v0, TBL[k].m0, TBL[k].a0, TBL[k].b0, TBL[k].d0, 2'b11);
            set_slot(1, TBL[k].v1, TBL[k].m1, TBL[k].a1, TBL[k].b1, TBL[k].d1, 2'b11);
            #1;
            chk($sformatf("R1/R2/R5 defer vec%0d", k), 64'(iss_defer), 64'({TBL[k].ed1, TBL[k].ed0}));
            chk($sformatf("R3 exec vec%0d", k), 64'(iss_exec),
                64'({TBL[k].v1 & ~TBL[k].ed1, TBL[k].v0 & ~TBL[k].ed0}));
            if (TBL[k].ed0) begin
                exp_rdy = {~prev_nt[TBL[k].b0], ~prev_nt[TBL[k].a0]};
                chk($sformatf("R4 dq_we vec%0d", k), 64'(dq_we[0]), 64'h1);
                chk($sformatf("R4 rdy vec%0d", k), 64'(dq_rdy[0]), 64'(exp_rdy));
                chk($sformatf("R4 opnd vec%0d", k), 64'(dq_opnd[0][0]),
                    exp_rdy[0] ? 64'(32'h100 + 32'(TBL[k].a0)) : 64'h0);
                chk($sformatf("R4 dst/op vec%0d", k), 64'({dq_dst[0], dq_op[0]}),
                    64'({TBL[k].d0, 8'h40}));
            end
            tick();
            chk($sformatf("R5 nt vec%0d", k), 64'(nt_vec), 64'(TBL[k].ent));
            prev_nt = TBL[k].ent;
        end

        // R2: unused source pointing at a pending register is ignored
        @(negedge clk); clear_in();
        set_slot(0, 1'b1, 1'b0, 5'd2, 5'd9, 5'd6, 2'b01);
        #1;
        chk("R2 unused src exec", 64'({iss_exec[0], iss_defer[0]}), 64'h2);
        tick();
        chk("R2 nt after unused", 64'(nt_vec), 64'h290);

        // R6: full queue with a deferring group
        @(negedge clk); clear_in();
        dq_full = 1'b1;
        set_slot(0, 1'b1, 1'b0, 5'd9, 5'd2, 5'd3, 2'b11);
        #1;
        chk("R6 stall", 64'(stall), 64'h1);
        chk("R6 no exec/defer/we", 64'({iss_exec, iss_defer, dq_we}), 64'h0);
        tick();
        chk("R6 nt held", 64'(nt_vec), 64'h290);

        // R6: full queue but nothing defers
        @(negedge clk); clear_in();
        dq_full = 1'b1;
        set_slot(0, 1'b1, 1'b0, 5'd2, 5'd3, 5'd4, 2'b11);
        #1;
        chk("R6 no stall", 64'(stall), 64'h0);
        chk("R3 exec with full queue", 64'(iss_exec[0]), 64'h1);
        tick();
        chk("R3 nt cleared", 64'(nt_vec), 64'h280);

        // R7: behind thread start
        @(negedge clk); clear_in();
        bt_start = 1'b1;
        tick();
        chk("R7 snt copy", 64'(snt_vec), 64'h280);
        chk("R7 w cleared", 64'(w_vec), 64'h0);

        // ahead thread rewrites r9
        @(negedge clk); clear_in();
        set_slot(0, 1'b1, 1'b0, 5'd2, 5'd3, 5'd9, 2'b11);
        tick();
        chk("R3 r9 cleared", 64'(nt_vec), 64'h080);

        // R8: behind write where nt and snt differ
        @(negedge clk); clear_in();
        bt_wr_valid = 1'b1; bt_wr_dst = 5'd9;
        #1;
        chk("R8 arch blocked", 64'(bt_arch_ok), 64'h0);
        tick();
        chk("R8 waw set", 64'(waw_vec), 64'h200);
        chk("R8 w set", 64'(w_vec), 64'h200);

        // R8: behind write where nt and snt agree
        @(negedge clk); clear_in();
        bt_wr_valid = 1'b1; bt_wr_dst = 5'd7;
        #1;
        chk("R8 arch allowed", 64'(bt_arch_ok), 64'h1);
        tick();
        chk("R8 waw unchanged", 64'(waw_vec), 64'h200);
        chk("R8 w both", 64'(w_vec), 64'h280);

        // R9: merge
        @(negedge clk); clear_in();
        bt_merge = 1'b1;
        tick();
        chk("R9 nt = snt&w", 64'(nt_vec), 64'h280);
        chk("R9 snt/w cleared", 64'({snt_vec, w_vec}), 64'h0);
        chk("R9 waw kept", 64'(waw_vec), 64'h200);

        // R11: write, merge and issue in one cycle
        @(negedge clk); clear_in();
        bt_start = 1'b1;
        tick();
        @(negedge clk); clear_in();
        bt_wr_valid = 1'b1; bt_wr_dst = 5'd5; bt_merge = 1'b1;
        set_slot(0, 1'b1, 1'b1, 5'd0, 5'd0, 5'd5, 2'b11);
        #1;
        chk("R11 arch ok", 64'(bt_arch_ok), 64'h1);
        chk("R11 defer", 64'(iss_defer[0]), 64'h1);
        tick();
        chk("R11 nt order", 64'(nt_vec), 64'h020);
        chk("R11 w cleared", 64'(w_vec), 64'h0);

        // R10: join
        @(negedge clk); clear_in();
        bt_join = 1'b1;
        #1;
        chk("R10 drop mask", 64'(drop_mask), 64'h200);
        tick();
        chk("R10 waw cleared", 64'(waw_vec), 64'h0);
        chk("R10 nt merged", 64'(nt_vec), 64'h0);

        @(negedge clk); clear_in();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule